// File: doc/BRIEF.md
# USB Transmit Endpoint Packet Controller

This block sequences the transmit side of a single USB endpoint. The CPU programs a byte-wide control register that holds an automatic-ready enable, an isochronous enable, a direction bit for a shared FIFO, a DMA enable and a DMA request mode. The same register carries two action bits: one that marks a packet ready and one that forces a data-toggle switch. A load strobe is pulsed once for each byte written into the endpoint FIFO. The controller counts these bytes against a programmable maximum packet size.

The block tells the serial engine when a packet is ready and which data PID to send (DATA0 or DATA1). It also emits a one-cycle FIFO flush pulse and requests DMA service. The serial engine reports each finished transaction, together with whether the host acknowledged it. The block then retires the packet or keeps it for a retry. In bulk and interrupt mode the packet is retired only on an acknowledge. In isochronous mode (device role only) the packet is retired on every completion, and the toggle stays at DATA0.

Top module: `usb_tx_ep_ctrl`

## Requirements
- R1: After reset the control readback, packet-ready, toggle, flush pulse and DMA request are all 0.
- R2: With auto-ready (bit 7) set, the load strobe that brings the byte count up to max_pkt_i raises pkt_rdy_o after that clock edge. Load strobes are not counted while pkt_rdy_o is high.
- R3: When fewer than max_pkt_i bytes have been loaded, or auto-ready is clear, pkt_rdy_o stays low. It rises only after a control write with bit 0 set.
- R4: In host mode (host_mode_i=1), the isochronous bit (bit 6) reads back as 0 and has no effect: the endpoint behaves as bulk/interrupt.
- R5: In device mode with bit 6 set, a completion clears pkt_rdy_o whether or not an acknowledge came, and data_tog_o is held at DATA0 (0).
- R6: A control write with bit 3 set produces a one-cycle flush_o pulse, clears pkt_rdy_o and flips data_tog_o (in bulk/interrupt mode), regardless of any acknowledge. Bit 3 reads back as 0. If an acknowledged completion arrives in the same cycle, the toggle flips only once.
- R7: With the SHARED_FIFO parameter at 1, tx_dir_o follows bit 5 (1 = TX, 0 = RX). With it at 0, tx_dir_o is always 1.
- R8: dma_req_o is 0 whenever the DMA enable bit (bit 4) is 0.
- R9: A write that clears the DMA mode bit (bit 2) while DMA enable is set, and does not also clear DMA enable, leaves the mode bit at 1.
- R10: In bulk/interrupt mode, an acknowledged completion clears pkt_rdy_o, clears the byte count and flips data_tog_o. A completion without an acknowledge changes neither.
- R11: In DMA mode 0 the request is high while pkt_rdy_o is low. In DMA mode 1 it is high only while auto-ready is set, pkt_rdy_o is low and the byte count is below max_pkt_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_mode_i | input | 1 | 1 = host role, 0 = device role |
| max_pkt_i | input | CNT_W | Maximum packet size in bytes |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control write data |
| ctl_rdata_o | output | 8 | Control readback |
| fifo_load_i | input | 1 | One byte written into the FIFO |
| txn_done_i | input | 1 | Serial engine finished a transaction |
| txn_ack_i | input | 1 | Host acknowledged that transaction |
| pkt_rdy_o | output | 1 | Packet ready for transmission |
| data_tog_o | output | 1 | Data PID toggle (0 = DATA0) |
| flush_o | output | 1 | One-cycle FIFO flush pulse |
| dma_req_o | output | 1 | DMA service request |
| tx_dir_o | output | 1 | Effective FIFO direction (1 = TX) |

## Verification
Two events can land on the same clock edge: a forced-toggle write, and an acknowledged completion of a pending packet. Both would flip the toggle and retire the packet. The bench drives them together in one vector while a packet is pending. It then expects exactly one flip, a single flush pulse and packet-ready low. A double flip would leave the toggle unchanged, so the check catches it. A second overlap is a write that clears the DMA mode bit while enable stays set. This is judged by reading back the control register on the next cycle.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;
  localparam int unsigned B_PKT_RDY  = 0;
  localparam int unsigned B_DMA_MODE = 2;
  localparam int unsigned B_FORCE    = 3;
  localparam int unsigned B_DMA_EN   = 4;
  localparam int unsigned B_DIR_TX   = 5;
  localparam int unsigned B_ISO      = 6;
  localparam int unsigned B_AUTO     = 7;

  typedef struct packed {
    logic auto_set;
    logic iso;
    logic dir_tx;
    logic dma_en;
    logic dma_mode;
  } ep_ctl_t;
endpackage

// File: rtl/usb_tx_ep_regs.sv
module usb_tx_ep_regs
  import usb_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output ep_ctl_t    ctl_o
);
  ep_ctl_t ctl_q;
  logic    mode_hold;

  // mode may only drop together with, or after, enable
  assign mode_hold = ctl_q.dma_en & ctl_q.dma_mode & wdata_i[B_DMA_EN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (we_i) begin
      ctl_q.auto_set <= wdata_i[B_AUTO];
      ctl_q.iso      <= wdata_i[B_ISO];
      ctl_q.dir_tx   <= wdata_i[B_DIR_TX];
      ctl_q.dma_en   <= wdata_i[B_DMA_EN];
      ctl_q.dma_mode <= wdata_i[B_DMA_MODE] | mode_hold;
    end
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/usb_tx_byte_cnt.sv
module usb_tx_byte_cnt #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             hold_i,
  input  logic             clr_i,
  input  logic             auto_en_i,
  input  logic [CNT_W-1:0] max_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             below_max_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;
  logic             take;

  assign cnt_inc     = {1'b0, cnt_q} + 1'b1;
  assign below_max_o = cnt_q < max_i;
  assign take        = load_i & ~hold_i & below_max_o;
  assign hit_o       = take & auto_en_i & (cnt_inc == {1'b0, max_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (take)  cnt_q <= cnt_inc[CNT_W-1:0];
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/usb_tx_pkt_seq.sv
module usb_tx_pkt_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic iso_i,
  input  logic force_i,
  input  logic sw_set_i,
  input  logic auto_hit_i,
  input  logic done_i,
  input  logic ack_i,
  output logic pkt_rdy_o,
  output logic tog_o,
  output logic flush_o,
  output logic cnt_clr_o
);
  logic rdy_q, tog_q, flush_q;
  logic rdy_d, tog_d, clr;

  always_comb begin
    rdy_d = rdy_q;
    tog_d = tog_q;
    clr   = 1'b0;
    if (force_i) begin
      rdy_d = 1'b0;
      clr   = 1'b1;
      tog_d = iso_i ? 1'b0 : ~tog_q;
    end else if (done_i && rdy_q && iso_i) begin
      rdy_d = 1'b0;
      clr   = 1'b1;
      tog_d = 1'b0;
    end else if (done_i && rdy_q && ack_i) begin
      rdy_d = 1'b0;
      clr   = 1'b1;
      tog_d = ~tog_q;
    end else if (sw_set_i || auto_hit_i) begin
      rdy_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q   <= 1'b0;
      tog_q   <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      rdy_q   <= rdy_d;
      tog_q   <= tog_d;
      flush_q <= force_i;
    end
  end

  assign pkt_rdy_o = rdy_q;
  assign tog_o     = tog_q;
  assign flush_o   = flush_q;
  assign cnt_clr_o = clr;
endmodule

// File: rtl/usb_tx_dma_req.sv
module usb_tx_dma_req (
  input  logic en_i,
  input  logic mode_i,
  input  logic auto_en_i,
  input  logic pkt_rdy_i,
  input  logic below_max_i,
  output logic req_o
);
  logic req_m0, req_m1;
  assign req_m0 = ~pkt_rdy_i;
  assign req_m1 = auto_en_i & ~pkt_rdy_i & below_max_i;
  assign req_o  = en_i & (mode_i ? req_m1 : req_m0);
endmodule

// File: rtl/usb_tx_ep_ctrl.sv
module usb_tx_ep_ctrl
  import usb_tx_pkg::*;
#(
  parameter int unsigned CNT_W       = 11,
  parameter bit          SHARED_FIFO = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_mode_i,
  input  logic [CNT_W-1:0] max_pkt_i,
  input  logic             ctl_we_i,
  input  logic [7:0]       ctl_wdata_i,
  output logic [7:0]       ctl_rdata_o,
  input  logic             fifo_load_i,
  input  logic             txn_done_i,
  input  logic             txn_ack_i,
  output logic             pkt_rdy_o,
  output logic             data_tog_o,
  output logic             flush_o,
  output logic             dma_req_o,
  output logic             tx_dir_o
);
  ep_ctl_t          ctl;
  logic             iso_eff, force_wr, sw_set;
  logic             cnt_clr, below_max, auto_hit, pkt_rdy;
  logic [CNT_W-1:0] cnt;
  logic             unused_bit1;

  assign unused_bit1 = ctl_wdata_i[1];
  assign iso_eff  = ctl.iso & ~host_mode_i;
  assign force_wr = ctl_we_i & ctl_wdata_i[B_FORCE];
  assign sw_set   = ctl_we_i & ctl_wdata_i[B_PKT_RDY];

  usb_tx_ep_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctl_we_i),
    .wdata_i (ctl_wdata_i),
    .ctl_o   (ctl)
  );

  usb_tx_byte_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (fifo_load_i),
    .hold_i      (pkt_rdy),
    .clr_i       (cnt_clr),
    .auto_en_i   (ctl.auto_set),
    .max_i       (max_pkt_i),
    .cnt_o       (cnt),
    .below_max_o (below_max),
    .hit_o       (auto_hit)
  );

  usb_tx_pkt_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .iso_i      (iso_eff),
    .force_i    (force_wr),
    .sw_set_i   (sw_set),
    .auto_hit_i (auto_hit),
    .done_i     (txn_done_i),
    .ack_i      (txn_ack_i),
    .pkt_rdy_o  (pkt_rdy),
    .tog_o      (data_tog_o),
    .flush_o    (flush_o),
    .cnt_clr_o  (cnt_clr)
  );

  usb_tx_dma_req u_dma (
    .en_i        (ctl.dma_en),
    .mode_i      (ctl.dma_mode),
    .auto_en_i   (ctl.auto_set),
    .pkt_rdy_i   (pkt_rdy),
    .below_max_i (below_max),
    .req_o       (dma_req_o)
  );

  generate
    if (SHARED_FIFO) begin : g_shared
      assign tx_dir_o = ctl.dir_tx;
    end else begin : g_dedicated
      assign tx_dir_o = 1'b1;
    end
  endgenerate

  assign pkt_rdy_o   = pkt_rdy;
  assign ctl_rdata_o = {ctl.auto_set, iso_eff, ctl.dir_tx, ctl.dma_en,
                        1'b0, ctl.dma_mode, 1'b0, pkt_rdy};
endmodule

// File: rtl/usb_tx_ep_ctrl_chk.sv
module usb_tx_ep_ctrl_chk #(
  parameter int unsigned CNT_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             host_mode_i,
  input logic [CNT_W-1:0] max_pkt_i,
  input logic             ctl_we_i,
  input logic [7:0]       ctl_wdata_i,
  input logic [7:0]       ctl_rdata_o,
  input logic             fifo_load_i,
  input logic             txn_done_i,
  input logic             txn_ack_i,
  input logic             pkt_rdy_o,
  input logic             data_tog_o,
  input logic             flush_o,
  input logic             dma_req_o,
  input logic [CNT_W-1:0] cnt
);
  logic [CNT_W:0] cnt_next;
  assign cnt_next = {1'b0, cnt} + 1'b1;

  p_auto_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_rdata_o[7] && fifo_load_i && !pkt_rdy_o && cnt_next == {1'b0, max_pkt_i}
     && !(ctl_we_i && ctl_wdata_i[3])) |=> pkt_rdy_o);

  p_host_no_iso_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_mode_i |-> !ctl_rdata_o[6]);

  p_iso_retire_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_rdata_o[6] && txn_done_i && pkt_rdy_o && !ctl_we_i) |=> (!pkt_rdy_o && !data_tog_o));

  p_force_flush_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && ctl_wdata_i[3]) |=> (flush_o && !pkt_rdy_o));

  p_dma_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_rdata_o[4] |-> !dma_req_o);

  p_mode_guard_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_rdata_o[4] && ctl_rdata_o[2] && ctl_we_i && ctl_wdata_i[4] && !ctl_wdata_i[2])
    |=> ctl_rdata_o[2]);

  p_nack_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_rdata_o[6] && txn_done_i && !txn_ack_i && pkt_rdy_o && !ctl_we_i)
    |=> (pkt_rdy_o && $stable(data_tog_o)));
endmodule

bind usb_tx_ep_ctrl usb_tx_ep_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .host_mode_i (host_mode_i),
  .max_pkt_i   (max_pkt_i),
  .ctl_we_i    (ctl_we_i),
  .ctl_wdata_i (ctl_wdata_i),
  .ctl_rdata_o (ctl_rdata_o),
  .fifo_load_i (fifo_load_i),
  .txn_done_i  (txn_done_i),
  .txn_ack_i   (txn_ack_i),
  .pkt_rdy_o   (pkt_rdy_o),
  .data_tog_o  (data_tog_o),
  .flush_o     (flush_o),
  .dma_req_o   (dma_req_o),
  .cnt         (cnt)
);

// File: tb/usb_tx_ep_ctrl_tb.sv
module usb_tx_ep_ctrl_tb;
  localparam int unsigned CNT_W = 11;
  localparam int unsigned NV    = 18;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             host_mode = 1'b0;
  logic [CNT_W-1:0] max_pkt = 11'd3;
  logic             we = 1'b0;
  logic [7:0]       wdata = 8'h00;
  logic [7:0]       rdata;
  logic             load = 1'b0, done = 1'b0, ack = 1'b0;
  logic             rdy, tog, flush, req, dir;
  int               errors = 0;
  int               checks = 0;

  always #10 clk = ~clk;

  usb_tx_ep_ctrl #(.CNT_W(CNT_W), .SHARED_FIFO(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .host_mode_i(host_mode), .max_pkt_i(max_pkt),
    .ctl_we_i(we), .ctl_wdata_i(wdata), .ctl_rdata_o(rdata),
    .fifo_load_i(load), .txn_done_i(done), .txn_ack_i(ack),
    .pkt_rdy_o(rdy), .data_tog_o(tog), .flush_o(flush), .dma_req_o(req),
    .tx_dir_o(dir)
  );

  // {we, wdata, load, done, ack, exp rdy, exp tog, exp flush, exp req}, max_pkt = 3
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 8'h90, 3'b000, 4'b0001},  // auto, dma en, mode 0
    {1'b0, 8'h00, 3'b100, 4'b0001},
    {1'b0, 8'h00, 3'b100, 4'b0001},
    {1'b0, 8'h00, 3'b100, 4'b1000},  // R2 third byte sets ready
    {1'b0, 8'h00, 3'b011, 4'b0101},  // R10 ack retires, toggle flips
    {1'b0, 8'h00, 3'b100, 4'b0101},
    {1'b1, 8'h91, 3'b000, 4'b1100},  // R3 software set on short packet
    {1'b0, 8'h00, 3'b010, 4'b1100},  // R10 no ack keeps
    {1'b0, 8'h00, 3'b011, 4'b0001},
    {1'b1, 8'h98, 3'b000, 4'b0111},  // R6 force
    {1'b0, 8'h00, 3'b000, 4'b0101},
    {1'b1, 8'h94, 3'b000, 4'b0101},  // R11 mode 1
    {1'b0, 8'h00, 3'b100, 4'b0101},
    {1'b0, 8'h00, 3'b100, 4'b0101},
    {1'b0, 8'h00, 3'b100, 4'b1100},  // R11 request drops on auto-set
    {1'b1, 8'h80, 3'b000, 4'b1100},  // R8 enable and mode cleared together
    {1'b1, 8'h88, 3'b011, 4'b0010},  // R6 force with acked completion
    {1'b0, 8'h00, 3'b000, 4'b0000}
  };

  task automatic chk(input string req_tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    we = 1'b0; wdata = 8'h00; load = 1'b0; done = 1'b0; ack = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    we = 1'b1; wdata = d;
    step();
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 in reset", {rdata[7:0]}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", {4'b0, rdy, tog, flush, req}, 8'h00);
    chk("R1 readback", rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      we = VEC[i][15]; wdata = VEC[i][14:7];
      load = VEC[i][6]; done = VEC[i][5]; ack = VEC[i][4];
      step();
      chk($sformatf("R2/R3/R6/R8/R10/R11 vec %0d", i), {4'b0, rdy, tog, flush, req},
          {4'b0, VEC[i][3:0]});
    end

    // R9 mode guard
    do_reset();
    wr(8'h94);
    wr(8'h90);
    chk("R9 mode kept", rdata, 8'h94);
    wr(8'h80);
    chk("R9 mode cleared with enable", rdata, 8'h80);

    // R6 force bit reads 0, R7 direction
    wr(8'h28);
    chk("R6 force reads 0 / R7", rdata, 8'h20);
    chk("R7 dir tx", {7'b0, dir}, 8'h01);
    wr(8'h00);
    chk("R7 dir rx", {7'b0, dir}, 8'h00);

    // R3 short packet with auto-set
    wr(8'h80);
    load = 1'b1; step();
    load = 1'b1; step();
    step();
    chk("R3 short packet not ready", {7'b0, rdy}, 8'h00);

    // R4 host mode: iso ignored
    do_reset();
    host_mode = 1'b1;
    wr(8'hC0);
    chk("R4 iso reads 0 in host", rdata, 8'h80);
    wr(8'hC1);
    done = 1'b1; step();
    chk("R4 no-ack keeps packet", {7'b0, rdy}, 8'h01);
    done = 1'b1; ack = 1'b1; step();
    chk("R4 bulk ack flips toggle", {6'b0, rdy, tog}, 8'h01);

    // R5 device iso
    host_mode = 1'b0;
    @(negedge clk);
    chk("R5 iso reads 1 in device", rdata, 8'hC0);
    wr(8'hC1);
    done = 1'b1; step();
    chk("R5 iso retire without ack", {6'b0, rdy, tog}, 8'h00);
    wr(8'hC8);
    chk("R5 force holds DATA0 in iso", {6'b0, flush, tog}, 8'h02);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule